// File: doc/BRIEF.md
# SIMD Warp Issue Sequencer

This block decides, cycle by cycle, which resident warp a multiprocessor with a narrow bank of scalar lanes is working on. A warp is a group of 32 threads that always run the same instruction. The multiprocessor has only 8 lanes, so each warp instruction is issued as 4 back-to-back beats of 8 threads. In each beat every lane works on the same instruction of the same warp. Lane j in beat k takes thread k*8 + j.

Each resident warp presents a ready flag and a 32-bit active-thread mask. A thread is inactive when it sits on the untaken side of a divergent branch, or when the warp is only partly filled. An inactive thread leaves its lane idle for that beat, and no other work is placed on that lane. Ready warps take turns in round-robin order. The turn moves on only at the end of a whole warp instruction, so a warp instruction is never split and each selection holds the lanes for at least 4 cycles. Between 1 and 32 warps can be resident, and the default is 24.

All outputs come from registers. The sequence of warp ids, beat numbers and lane enables drives the lane datapath directly.

Top module: `warp_issue_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears its state. After that edge `issue_valid`, `lane_en`, `issue_warp` and `issue_beat` are all 0, and the round-robin search begins at warp 0.
- R2: A selected warp occupies exactly 4 consecutive cycles. `issue_beat` reads 0, 1, 2, 3 in those cycles and `issue_warp` is unchanged throughout.
- R3: Lane j of `thread_idx` (bits j*5 to j*5+4) always equals `issue_beat`*8 + j.
- R4: The mask of warp w is held in `warp_mask` bits w*32 to w*32+31, and bit t of that mask belongs to thread t. The block captures the mask at the edge that selects the warp. In beat k, `lane_en` bit j equals bit k*8 + j of the captured mask. A change to `warp_mask` after that edge has no effect until the next selection.
- R5: A new selection is made at an edge where no warp is issuing, or at the edge that ends beat 3. The block picks the first warp whose `warp_ready` bit is high, searching upward from the warp after the previous selection and wrapping past the last warp to warp 0.
- R6: If a selected warp's `warp_ready` falls after its selection edge, its remaining beats are still issued.
- R7: If no warp is ready at a selection edge, the next cycle has `issue_valid` = 0, `lane_en` = 0, `issue_warp` = 0 and `issue_beat` = 0.
- R8: When a ready warp is found at the edge that ends beat 3, its beat 0 follows in the next cycle, with no idle cycle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| warp_ready | input | NUM_WARPS | Per-warp ready flag |
| warp_mask | input | NUM_WARPS*32 | Per-warp active-thread masks, 32 bits per warp |
| issue_valid | output | 1 | A warp beat is being issued this cycle |
| issue_warp | output | clog2(NUM_WARPS) | Warp id of the current beat |
| issue_beat | output | 2 | Beat number 0 to 3 within the warp instruction |
| lane_en | output | 8 | Per-lane enable for the current beat |
| thread_idx | output | 8*5 | Per-lane thread index within the warp |

## Verification
The checker assumes that `warp_ready` and `warp_mask` are sampled only at clock edges, and that the ready vector seen at a selection edge is the one the choice was based on. It also assumes that no warp id at or above NUM_WARPS is ever flagged. The stimulus changes inputs only on the falling clock edge and drives just the NUM_WARPS defined ready bits. It also lowers ready flags and rewrites masks in the middle of a warp instruction, so the capture and no-split rules are exercised rather than assumed.

// File: rtl/warp_seq_pkg.sv
package warp_seq_pkg;
  localparam int unsigned LANES_DEF     = 8;
  localparam int unsigned WARP_SIZE_DEF = 32;
  localparam int unsigned NUM_WARPS_DEF = 24;

  function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned count);
    return (cur + 1 >= count) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
  parameter int unsigned N = 24,
  parameter int unsigned W = 5
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] start,
  output logic         found,
  output logic [W-1:0] pick
);
  always_comb begin
    logic [W:0]   sum;
    logic [W-1:0] cand;
    found = 1'b0;
    pick  = '0;
    for (int off = 0; off < int'(N); off++) begin
      sum = {1'b0, start} + (W+1)'(off);
      if (sum >= (W+1)'(N)) sum = sum - (W+1)'(N);
      cand = sum[W-1:0];
      if (!found && req[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end
endmodule

// File: rtl/warp_lane_map.sv
module warp_lane_map #(
  parameter int unsigned LANES     = 8,
  parameter int unsigned WARP_SIZE = 32
) (
  input  logic [WARP_SIZE-1:0]                  mask,
  input  logic [$clog2(WARP_SIZE/LANES)-1:0]    beat,
  output logic [LANES-1:0]                      en
);
  localparam int unsigned LB = $clog2(LANES);

  for (genvar j = 0; j < int'(LANES); j++) begin : g_lane
    assign en[j] = mask[{beat, LB'(j)}];
  end
endmodule

// File: rtl/warp_issue_seq.sv
module warp_issue_seq
  import warp_seq_pkg::*;
#(
  parameter int unsigned NUM_WARPS = NUM_WARPS_DEF,
  parameter int unsigned LANES     = LANES_DEF,
  parameter int unsigned WARP_SIZE = WARP_SIZE_DEF,
  localparam int unsigned WID_W    = $clog2(NUM_WARPS),
  localparam int unsigned BEATS    = WARP_SIZE / LANES,
  localparam int unsigned BEAT_W   = $clog2(BEATS),
  localparam int unsigned TID_W    = $clog2(WARP_SIZE)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_WARPS-1:0]       warp_ready,
  input  logic [NUM_WARPS*WARP_SIZE-1:0] warp_mask,
  output logic                       issue_valid,
  output logic [WID_W-1:0]           issue_warp,
  output logic [BEAT_W-1:0]          issue_beat,
  output logic [LANES-1:0]           lane_en,
  output logic [LANES*TID_W-1:0]     thread_idx
);
  localparam int unsigned LB = $clog2(LANES);

  logic [WARP_SIZE-1:0] mask_q, mask_d;
  logic [WID_W-1:0]     ptr_q, ptr_d;
  logic                 valid_d;
  logic [WID_W-1:0]     warp_d;
  logic [BEAT_W-1:0]    beat_d;
  logic [LANES-1:0]     en_d;
  logic                 found;
  logic [WID_W-1:0]     pick;
  logic                 boundary;

  warp_rr_pick #(.N(NUM_WARPS), .W(WID_W)) i_pick (
    .req   (warp_ready),
    .start (ptr_q),
    .found (found),
    .pick  (pick)
  );

  assign boundary = !issue_valid || (issue_beat == BEAT_W'(BEATS-1));

  always_comb begin
    valid_d = issue_valid;
    warp_d  = issue_warp;
    beat_d  = issue_beat + BEAT_W'(1);
    mask_d  = mask_q;
    ptr_d   = ptr_q;
    if (boundary) begin
      beat_d = '0;
      if (found) begin
        valid_d = 1'b1;
        warp_d  = pick;
        mask_d  = warp_mask[int'(pick)*WARP_SIZE +: WARP_SIZE];
        ptr_d   = WID_W'(wrap_next(int'(pick), NUM_WARPS));
      end else begin
        valid_d = 1'b0;
        warp_d  = '0;
        mask_d  = '0;
      end
    end
  end

  warp_lane_map #(.LANES(LANES), .WARP_SIZE(WARP_SIZE)) i_map (
    .mask (mask_d),
    .beat (beat_d),
    .en   (en_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      issue_beat  <= '0;
      lane_en     <= '0;
      mask_q      <= '0;
      ptr_q       <= '0;
    end else begin
      issue_valid <= valid_d;
      issue_warp  <= warp_d;
      issue_beat  <= beat_d;
      lane_en     <= valid_d ? en_d : '0;
      mask_q      <= mask_d;
      ptr_q       <= ptr_d;
    end
  end

  for (genvar j = 0; j < int'(LANES); j++) begin : g_tid
    assign thread_idx[j*TID_W +: TID_W] = {issue_beat, LB'(j)};
  end
endmodule

// File: rtl/warp_issue_seq_chk.sv
module warp_issue_seq_chk #(
  parameter int unsigned NUM_WARPS = 24,
  parameter int unsigned LANES     = 8,
  parameter int unsigned WARP_SIZE = 32,
  localparam int unsigned WID_W    = $clog2(NUM_WARPS),
  localparam int unsigned BEATS    = WARP_SIZE / LANES,
  localparam int unsigned BEAT_W   = $clog2(BEATS),
  localparam int unsigned TID_W    = $clog2(WARP_SIZE),
  localparam int unsigned LB       = $clog2(LANES)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_WARPS-1:0]   warp_ready,
  input logic                   issue_valid,
  input logic [WID_W-1:0]       issue_warp,
  input logic [BEAT_W-1:0]      issue_beat,
  input logic [LANES-1:0]       lane_en,
  input logic [LANES*TID_W-1:0] thread_idx
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS-1);

  logic [NUM_WARPS-1:0] ready_q;
  always_ff @(posedge clk) ready_q <= warp_ready;

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |-> (lane_en == '0 && issue_warp == '0 && issue_beat == '0));

  assert_beat_step_R2: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_beat != LAST) |=>
      (issue_valid && issue_beat == $past(issue_beat) + BEAT_W'(1) && $stable(issue_warp)));

  assert_start_beat_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(issue_valid) |-> issue_beat == '0);

  assert_no_ready_R7: assert property (@(posedge clk) disable iff (rst)
    ((!issue_valid || issue_beat == LAST) && warp_ready == '0) |=> !issue_valid);

  assert_pick_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_beat == '0) |-> ready_q[issue_warp]);

  assert_ready_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_beat == LAST && warp_ready != '0) |=> (issue_valid && issue_beat == '0));

  assert_lane0_tid_R3: assert property (@(posedge clk) disable iff (rst)
    thread_idx[TID_W-1:0] == {issue_beat, LB'(0)});
endmodule

bind warp_issue_seq warp_issue_seq_chk #(
  .NUM_WARPS (NUM_WARPS),
  .LANES     (LANES),
  .WARP_SIZE (WARP_SIZE)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .warp_ready  (warp_ready),
  .issue_valid (issue_valid),
  .issue_warp  (issue_warp),
  .issue_beat  (issue_beat),
  .lane_en     (lane_en),
  .thread_idx  (thread_idx)
);

// File: tb/test_warp_issue_seq.sv
module test_warp_issue_seq;
  localparam int NW = 24;
  localparam int LN = 8;
  localparam int WS = 32;
  localparam int WID_W = $clog2(NW);
  localparam int TID_W = 5;
  localparam int CLK_PERIOD = 10;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NW-1:0]        warp_ready = '0;
  logic [NW*WS-1:0]     warp_mask = '0;
  logic                 issue_valid;
  logic [WID_W-1:0]     issue_warp;
  logic [1:0]           issue_beat;
  logic [LN-1:0]        lane_en;
  logic [LN*TID_W-1:0]  thread_idx;

  int n_checks = 0;
  int n_fail   = 0;

  int          m_valid = 0;
  int          m_warp  = 0;
  int          m_beat  = 0;
  int          m_ptr   = 0;
  logic [31:0] m_mask  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_seq #(.NUM_WARPS(NW), .LANES(LN), .WARP_SIZE(WS)) i_warp_issue_seq (
    .clk, .rst, .warp_ready, .warp_mask,
    .issue_valid, .issue_warp, .issue_beat, .lane_en, .thread_idx
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_lanes();
    return m_valid != 0 ? int'(m_mask[m_beat*8 +: 8]) : 0;
  endfunction

  task automatic check_outputs(input string ph);
    chk(int'(issue_valid), m_valid, ph, "issue_valid");
    chk(int'(issue_warp), m_warp, ph, "issue_warp");
    chk(int'(issue_beat), m_beat, "R2", "issue_beat");
    chk(int'(lane_en), exp_lanes(), "R4", "lane_en");
    for (int j = 0; j < LN; j++)
      chk(int'(thread_idx[j*TID_W +: TID_W]), m_beat*8 + j, "R3", "thread_idx");
  endtask

  task automatic model_step();
    if (m_valid == 0 || m_beat == 3) begin
      int hit = -1;
      for (int off = 0; off < NW; off++) begin
        int w = (m_ptr + off) % NW;
        if (hit < 0 && warp_ready[w]) hit = w;
      end
      m_beat = 0;
      if (hit >= 0) begin
        m_valid = 1; m_warp = hit; m_mask = warp_mask[hit*WS +: WS]; m_ptr = (hit + 1) % NW;
      end else begin
        m_valid = 0; m_warp = 0; m_mask = '0;
      end
    end else begin
      m_beat++;
    end
  endtask

  task automatic drive(input logic r, input logic [NW-1:0] rdy, input logic [NW*WS-1:0] msk,
                       input string ph);
    @(negedge clk);
    check_outputs(ph);
    rst = r; warp_ready = rdy; warp_mask = msk;
    if (r) begin
      m_valid = 0; m_warp = 0; m_beat = 0; m_ptr = 0; m_mask = '0;
    end else begin
      model_step();
    end
  endtask

  function automatic logic [NW*WS-1:0] rand_masks();
    logic [NW*WS-1:0] v;
    for (int w = 0; w < NW; w++) v[w*WS +: WS] = $urandom;
    return v;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [NW*WS-1:0] mk;
    logic [NW-1:0]    rd;
    void'($urandom(32'd2024));
    mk = rand_masks();
    // R1: reset held, ready asserted but ignored
    repeat (3) drive(1'b1, '1, mk, "R1");
    drive(1'b0, '0, mk, "R1");
    // R7: nothing ready
    repeat (4) drive(1'b0, '0, mk, "R7");
    // R5: search starts at warp 0 after reset, picks 3 then 7 then 3
    rd = '0; rd[3] = 1'b1; rd[7] = 1'b1;
    repeat (14) drive(1'b0, rd, mk, "R5");
    // R8: all ready, full masks, back-to-back instructions
    repeat (16) drive(1'b0, '1, '1, "R8");
    // R6: ready for one edge only, instruction still completes
    repeat (4) drive(1'b0, '0, mk, "R7");
    rd = '0; rd[10] = 1'b1;
    drive(1'b0, rd, mk, "R6");
    repeat (6) drive(1'b0, '0, mk, "R6");
    // R4: partial mask captured, later rewrite ignored mid instruction
    mk = '0; mk[5*WS +: WS] = 32'h8001_00FF;
    rd = '0; rd[5] = 1'b1;
    drive(1'b0, rd, mk, "R4");
    mk[5*WS +: WS] = 32'h0F0F_FFFF;
    repeat (3) drive(1'b0, '0, mk, "R4");
    repeat (5) drive(1'b0, rd, mk, "R4");
    // R5: wrap from last warp to warp 0
    rd = '0; rd[NW-1] = 1'b1; rd[0] = 1'b1;
    repeat (16) drive(1'b0, rd, rand_masks(), "R5");
    // random traffic with mid-instruction reset pulses
    for (int c = 0; c < 600; c++) begin
      logic [NW-1:0] r;
      r = NW'($urandom & $urandom & $urandom);
      if ($urandom_range(0, 9) == 0) r = '0;
      if ($urandom_range(0, 3) == 0) mk = rand_masks();
      drive(($urandom_range(0, 199) == 0), r, mk, "R5");
    end
    drive(1'b0, '0, mk, "R7");
    repeat (6) drive(1'b0, '0, mk, "R7");
    finish_run();
  end
endmodule